// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer for a successive-approximation analog-to-digital converter. It takes a start request and a single comparator decision bit. It drives an N-bit trial code to an external DAC, pulses a sample-and-hold strobe when a conversion begins, and finds the input code by binary search. The search tests one bit per clock, starting at the most significant bit and ending at the least significant.

When a start is accepted, the controller spends one cycle acquiring the input with the hold strobe high. It then seeds the trial code with only the top bit set. On each following clock it reads the comparator, which reports whether the DAC level for the current trial code is above the held input. It clears the bit under test if so, and keeps it otherwise. It then sets the next lower bit.

After the last bit has been decided, the code is copied into a result register and an end-of-conversion level is raised. That level stays high until the next accepted start.

Top module: `sar_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in idle, with trial code 0, result 0, hold strobe low and end-of-conversion low.
- R2: A start request seen in idle makes the hold strobe high for exactly the next cycle. During that cycle the trial code is 0 and end-of-conversion is low.
- R3: On the clock edge that ends the hold cycle, the trial code becomes a value with only bit N-1 set.
- R4: The comparator input is 1 when the DAC level is above the held input. It is sampled on each of the N edges that follow the seed. A 1 clears the bit under test and a 0 keeps it, and on the same edge the next lower bit is set to 1.
- R5: End-of-conversion rises on the (N+1)th clock edge after the edge that accepted the start, and stays low on all edges in between.
- R6: For an ideal comparator and an integer input v in 0..2^N-1, the result and the final trial code both equal v.
- R7: The result output changes only on the edge where end-of-conversion rises. It keeps the previous result while a conversion runs and while the controller is idle.
- R8: End-of-conversion is a level that stays high, with the trial code and result unchanged, until the next accepted start clears it.
- R9: A start request made while a conversion is running has no effect: the running conversion keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| cmp_i | input | 1 | Comparator decision: 1 when DAC level is above the held input |
| trial_o | output | N | Trial code driven to the DAC |
| hold_o | output | 1 | Sample-and-hold strobe, one cycle per conversion |
| eoc_o | output | 1 | End-of-conversion level |
| result_o | output | N | Converted code, updated only when a conversion completes |

## Verification
The embedded properties watch every cycle for the following. The hold strobe must be a single-cycle pulse. The seed must follow the sample cycle. Exactly one bit may be under test during a search. Each tested bit must be cleared or kept according to the comparator. The result may change only on completion, and end-of-conversion must persist. A restart must never occur mid-search. Only the bench's scenarios show that the full conversion reproduces the input value across the code range, including both end codes. They also show that end-of-conversion lands on exactly the (N+1)th edge, that an ignored mid-search start leaves the result intact, and that a reset in the middle of a search returns a clean idle state.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // controller phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } phase_e;

    // per-cycle commands from the sequencer to the code register
    typedef struct packed {
        logic wipe;   // accepted start: clear the trial code
        logic seed;   // end of sample cycle: load top bit only
        logic judge;  // search cycle: apply comparator to bit under test
        logic last;   // final search cycle: capture result
    } step_t;

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    output step_t        step_o,
    output logic [N-1:0] probe_o,
    output logic         hold_o,
    output logic         eoc_o
);

    localparam logic [N-1:0] TOP_BIT = {1'b1, {(N-1){1'b0}}};

    phase_e       phase_q;
    logic [N-1:0] probe_q;
    logic         eoc_q;
    logic         accept;

    assign accept = (phase_q == PH_IDLE) && start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            probe_q <= '0;
            eoc_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_SAMPLE;
                        eoc_q   <= 1'b0;
                    end
                end
                PH_SAMPLE: begin
                    phase_q <= PH_CONV;
                    probe_q <= TOP_BIT;
                end
                PH_CONV: begin
                    probe_q <= probe_q >> 1;
                    if (probe_q[0]) begin
                        phase_q <= PH_IDLE;
                        eoc_q   <= 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        step_o.wipe  = accept;
        step_o.seed  = (phase_q == PH_SAMPLE);
        step_o.judge = (phase_q == PH_CONV);
        step_o.last  = (phase_q == PH_CONV) && probe_q[0];
    end

    assign probe_o = probe_q;
    assign hold_o  = (phase_q == PH_SAMPLE);
    assign eoc_o   = eoc_q;

    // R2
    hold_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        hold_o |=> !hold_o);

    // R3
    seed_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SAMPLE) |=> (phase_q == PH_CONV) && (probe_q == TOP_BIT));

    // R4
    single_probe_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CONV) |-> ($countones(probe_q) == 1));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase_q != PH_IDLE) && start_i) |=> (phase_q != PH_SAMPLE));

    // R8
    eoc_level_chk: assert property (@(posedge clk) disable iff (rst)
        (eoc_q && !accept) |=> eoc_q);

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step_i,
    input  logic [N-1:0] probe_i,
    input  logic         cmp_i,
    output logic [N-1:0] code_o,
    output logic [N-1:0] result_o
);

    logic [N-1:0] code_q;
    logic [N-1:0] code_d;
    logic [N-1:0] follow;
    logic [N-1:0] result_q;

    // bit k is set next when bit k+1 is the one under test
    assign follow = probe_i >> 1;

    for (genvar k = 0; k < N; k++) begin : g_cell
        logic bit_d;

        always_comb begin
            bit_d = code_q[k];
            if (step_i.wipe) begin
                bit_d = 1'b0;
            end else if (step_i.seed) begin
                bit_d = (k == N - 1) ? 1'b1 : 1'b0;
            end else if (step_i.judge) begin
                if (probe_i[k])
                    bit_d = code_q[k] & ~cmp_i;
                else if (follow[k])
                    bit_d = 1'b1;
            end
        end

        assign code_d[k] = bit_d;

        // R4
        cleared_chk: assert property (@(posedge clk) disable iff (rst)
            (step_i.judge && probe_i[k] && cmp_i) |=> !code_q[k]);

        // R4
        kept_chk: assert property (@(posedge clk) disable iff (rst)
            (step_i.judge && probe_i[k] && !cmp_i) |=> code_q[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            result_q <= '0;
        end else begin
            code_q <= code_d;
            if (step_i.last)
                result_q <= code_d;
        end
    end

    assign code_o   = code_q;
    assign result_o = result_q;

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_i.last |=> $stable(result_q));

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic [N-1:0] trial_o,
    output logic         hold_o,
    output logic         eoc_o,
    output logic [N-1:0] result_o
);

    step_t        step;
    logic [N-1:0] probe;

    sar_sequencer #(.N(N)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .step_o  (step),
        .probe_o (probe),
        .hold_o  (hold_o),
        .eoc_o   (eoc_o)
    );

    sar_code_reg #(.N(N)) u_code (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .probe_i  (probe),
        .cmp_i    (cmp_i),
        .code_o   (trial_o),
        .result_o (result_o)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (trial_o == '0) && !eoc_o && !hold_o && (result_o == '0));

    // R6
    result_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_o) |-> (result_o == trial_o));

endmodule

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;

    localparam int N = 8;
    localparam int NV = 10;
    localparam int VIN_TAB [NV] = '{0, 255, 128, 127, 1, 254, 85, 170, 90, 200};
    localparam int EXP_TAB [NV] = '{0, 255, 128, 127, 1, 254, 85, 170, 90, 200};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         cmp;
    logic [N-1:0] trial;
    logic         hold;
    logic         eoc;
    logic [N-1:0] result;
    int           vin = 0;
    int           checks = 0;
    int           errors = 0;
    int           prev_res = 0;

    always #2 clk = ~clk;

    // ideal DAC plus comparator
    assign cmp = (int'(trial) > vin);

    sar_ctrl #(.N(N)) u0 (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .cmp_i    (cmp),
        .trial_o  (trial),
        .hold_o   (hold),
        .eoc_o    (eoc),
        .result_o (result)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input int v, input int expv, input bit poke);
        @(negedge clk);
        vin = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(hold == 1'b1, "R2 hold high", int'(hold), 1);
        check(trial == '0, "R2 trial zero in sample", int'(trial), 0);
        check(eoc == 1'b0, "R8 eoc cleared by start", int'(eoc), 0);
        @(negedge clk);
        check(int'(trial) == (1 << (N - 1)), "R3 seed", int'(trial), 1 << (N - 1));
        check(hold == 1'b0, "R2 hold one cycle", int'(hold), 0);
        for (int j = 1; j < N; j++) begin
            @(negedge clk);
            start = 1'b0;
            check(int'(trial) == (((v >> (N - j)) << (N - j)) | (1 << (N - 1 - j))),
                  "R4 search step", int'(trial),
                  ((v >> (N - j)) << (N - j)) | (1 << (N - 1 - j)));
            if (poke && j == 2) start = 1'b1; // R9 mid-search request
        end
        start = 1'b0;
        check(eoc == 1'b0, "R5 eoc low before last edge", int'(eoc), 0);
        check(int'(result) == prev_res, "R7 result held during search", int'(result), prev_res);
        @(negedge clk);
        check(eoc == 1'b1, "R5 eoc at edge N+1", int'(eoc), 1);
        check(int'(result) == expv, "R6 result", int'(result), expv);
        check(int'(trial) == expv, "R6 final trial", int'(trial), expv);
        prev_res = expv;
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(trial == '0 && result == '0, "R1 reset code", int'(trial), 0);
        check(!eoc && !hold, "R1 reset flags", int'(eoc), 0);

        for (int i = 0; i < NV; i++)
            convert(VIN_TAB[i], EXP_TAB[i], (i % 3) == 1);

        // R8 and R7: idle with eoc high, input moved
        vin = 17;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(eoc == 1'b1, "R8 eoc stays high", int'(eoc), 1);
            check(int'(result) == prev_res, "R7 result stable in idle", int'(result), prev_res);
            check(int'(trial) == prev_res, "R8 trial stable in idle", int'(trial), prev_res);
        end

        // R9 with a start held high across the whole search
        @(negedge clk);
        vin = 77;
        start = 1'b1;
        repeat (N + 1) @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(eoc == 1'b1 && int'(result) == 77, "R9 held start result", int'(result), 77);

        // R1 reset in the middle of a search
        @(negedge clk);
        vin = 33;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(trial == '0 && result == '0, "R1 mid-search reset code", int'(trial), 0);
        check(!eoc && !hold, "R1 mid-search reset flags", int'(eoc), 0);
        repeat (4) @(negedge clk);
        check(!eoc && trial == '0, "R1 stays idle", int'(trial), 0);

        prev_res = 0;
        convert(33, 33, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule